// File: doc/BRIEF.md
# Five-stage pipeline operand bypass selector

This block is the hazard logic that sits beside the execute stage of a five-stage in-order pipeline. For each of the two source register fields of the instruction now in EX, it decides where the operand comes from. It can take the value read from the register file during decode, or it can bypass the result held by the instruction in MEM or the one in WB. It compares register fields only. Whether the EX instruction really consumes a given source field has no effect, so a jump with no source fields still gets a select for whatever bits sit in those fields.

The same unit also requests a stall when the instruction in MEM is a load whose destination matches a source field of the EX instruction. The loaded word does not exist yet, so that MEM entry never supplies a bypass value. The block is purely combinational. The stall sequencing and the operand multiplexers that consume the selects belong to the surrounding pipeline.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses the code 2'b00 for the register-file value, 2'b01 for the MEM result and 2'b10 for the WB result. When no stage qualifies, the output is 2'b00.
- R2: When the MEM instruction writes a register (mem_reg_write=1), is not a load (mem_is_load=0) and its destination equals a source field, that operand's select is 2'b01.
- R3: When the WB instruction writes a register and its destination equals a source field that MEM does not supply, that operand's select is 2'b10.
- R4: When MEM and WB both qualify for the same operand, MEM wins and the select is 2'b01.
- R5: A stage with its write-enable flag cleared never drives a select and never causes a stall, even if its destination matches.
- R6: A destination of register 0 is never bypassed and never causes a stall, even when a source field is also 0.
- R7: When a register-writing load in MEM matches a source field, stall_req is 1 and that operand's select is not 2'b01. The select becomes 2'b10 if WB qualifies for that operand, and 2'b00 otherwise.
- R8: stall_req is 0 whenever no operand matches a register-writing load in MEM, including when MEM holds a non-load or a load to a different register.
- R9: The two operands are resolved independently, and both may select the same stage at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs1 | input | REG_AW | First source register field of the EX instruction |
| ex_rs2 | input | REG_AW | Second source register field of the EX instruction |
| mem_rd | input | REG_AW | Destination register of the MEM instruction |
| mem_reg_write | input | 1 | MEM instruction writes the register file |
| mem_is_load | input | 1 | MEM instruction takes its result from memory |
| wb_rd | input | REG_AW | Destination register of the WB instruction |
| wb_reg_write | input | 1 | WB instruction writes the register file |
| sel_rs1 | output | 2 | Source select for the first operand |
| sel_rs2 | output | 2 | Source select for the second operand |
| stall_req | output | 1 | Load-use hazard: the EX instruction must wait |

## Verification
The bench builds the unit with the default register-field width of five bits, which covers the whole 32-entry register space. That width brings both ends of the field into reach: register 0, which must never be bypassed, and register 31, the highest index, which must compare like any other. The directed cases include a MEM and WB pair contending for the same operand, and a load match that falls back to WB or to the register file. They also check cleared write-enables that must hide an otherwise matching destination.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source codes; the consuming mux decodes these values.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEM     = 2'b01,
        SRC_WB      = 2'b10
    } src_sel_e;

    localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fwd_stage_qual.sv
module fwd_stage_qual #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_OPS = 2
) (
    input  logic [NUM_OPS-1:0][REG_AW-1:0] src_regs,
    input  logic [REG_AW-1:0]              dst_reg,
    input  logic                           dst_wr,
    input  logic                           dst_load,
    output logic [NUM_OPS-1:0]             data_hit,
    output logic [NUM_OPS-1:0]             load_hit
);

    logic live;

    always_comb begin
        live = dst_wr && (dst_reg != '0);
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic same;
        always_comb begin
            same        = live && (src_regs[g] == dst_reg);
            data_hit[g] = same && !dst_load;
            load_hit[g] = same && dst_load;
        end
    end

endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output src_sel_e sel
);

    always_comb begin
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REGFILE;
        end
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_reg_write,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_reg_write,
    output logic [1:0]        sel_rs1,
    output logic [1:0]        sel_rs2,
    output logic              stall_req
);

    typedef struct packed {
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic       stall;
    } fwd_out_t;

    logic [NUM_OPS-1:0][REG_AW-1:0] srcs;
    logic [NUM_OPS-1:0]             mem_data_hit;
    logic [NUM_OPS-1:0]             mem_load_hit;
    logic [NUM_OPS-1:0]             wb_data_hit;
    logic [NUM_OPS-1:0]             wb_load_hit;
    src_sel_e                       op_sel [NUM_OPS];
    fwd_out_t                       out_d;

    always_comb begin
        srcs[0] = ex_rs1;
        srcs[1] = ex_rs2;
    end

    fwd_stage_qual #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_mem_q (
        .src_regs (srcs),
        .dst_reg  (mem_rd),
        .dst_wr   (mem_reg_write),
        .dst_load (mem_is_load),
        .data_hit (mem_data_hit),
        .load_hit (mem_load_hit)
    );

    // Write-back results are already complete, so WB is never a pending load.
    fwd_stage_qual #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_wb_q (
        .src_regs (srcs),
        .dst_reg  (wb_rd),
        .dst_wr   (wb_reg_write),
        .dst_load (1'b0),
        .data_hit (wb_data_hit),
        .load_hit (wb_load_hit)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_pick
        fwd_src_pick u_pick (
            .mem_hit (mem_data_hit[g]),
            .wb_hit  (wb_data_hit[g]),
            .sel     (op_sel[g])
        );
    end

    always_comb begin
        out_d       = '0;
        out_d.sel_a = op_sel[0];
        out_d.sel_b = op_sel[1];
        out_d.stall = |mem_load_hit || (|wb_load_hit);
    end

    assign sel_rs1   = out_d.sel_a;
    assign sel_rs2   = out_d.sel_b;
    assign stall_req = out_d.stall;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_reg_write,
    input logic              mem_is_load,
    input logic [REG_AW-1:0] wb_rd,
    input logic              wb_reg_write,
    input logic [1:0]        sel_rs1,
    input logic [1:0]        sel_rs2,
    input logic              stall_req
);

    logic known;

    always_comb begin
        known = !$isunknown({ex_rs1, ex_rs2, mem_rd, mem_reg_write, mem_is_load,
                             wb_rd, wb_reg_write, sel_rs1, sel_rs2, stall_req});
        if (known) begin
            // R6: a zero source field always reads the register file
            a_r6_zero_src: assert ((ex_rs1 != '0) || (sel_rs1 == 2'b00));
            // R5: no enabled writer means no bypass and no stall
            a_r5_no_writer: assert (mem_reg_write || wb_reg_write ||
                                    ((sel_rs1 == 2'b00) && (sel_rs2 == 2'b00) && !stall_req));
            // R7: a stall never comes with a MEM select
            a_r7_stall_no_mem: assert (!stall_req || ((sel_rs1 != 2'b01) && (sel_rs2 != 2'b01)));
            // R8: a non-load in MEM never stalls
            a_r8_no_load_no_stall: assert (mem_is_load || !stall_req);
            // R4: a qualifying non-load MEM match wins over WB
            a_r4_mem_priority: assert (!(mem_reg_write && !mem_is_load && (mem_rd != '0) &&
                                         (mem_rd == ex_rs2)) || (sel_rs2 == 2'b01));
        end
    end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;

    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic [AW-1:0] ex_rs1 = '0, ex_rs2 = '0, mem_rd = '0, wb_rd = '0;
    logic          mem_reg_write = 1'b0, mem_is_load = 1'b0, wb_reg_write = 1'b0;
    logic [1:0]    sel_rs1, sel_rs2;
    logic          stall_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fwd_unit #(.REG_AW(AW)) u0 (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd),
        .mem_reg_write(mem_reg_write), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .sel_rs1(sel_rs1), .sel_rs2(sel_rs2), .stall_req(stall_req)
    );

    task automatic drive(input int r1, input int r2, input int mrd, input bit mwr,
                         input bit mld, input int wrd, input bit wwr);
        @(negedge clk);
        ex_rs1 = AW'(r1); ex_rs2 = AW'(r2);
        mem_rd = AW'(mrd); mem_reg_write = mwr; mem_is_load = mld;
        wb_rd = AW'(wrd); wb_reg_write = wwr;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] e1, input logic [1:0] e2,
                         input logic es);
        n_checks++;
        if (sel_rs1 !== e1 || sel_rs2 !== e2 || stall_req !== es) begin
            n_fail++;
            $display("FAIL %s: got sel1=%b sel2=%b stall=%b, expected sel1=%b sel2=%b stall=%b",
                     req, sel_rs1, sel_rs2, stall_req, e1, e2, es);
        end
    endtask

    task automatic t_idle();
        drive(0, 0, 0, 0, 0, 0, 0);  check("R1 idle", 2'b00, 2'b00, 1'b0);
        drive(5, 9, 0, 0, 0, 0, 0);  check("R1 no match", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_mem();
        drive(3, 7, 3, 1, 0, 0, 0);  check("R2 mem rs1", 2'b01, 2'b00, 1'b0);
        drive(31, 1, 31, 1, 0, 2, 1); check("R2 mem x31", 2'b01, 2'b00, 1'b0);
    endtask

    task automatic t_wb();
        drive(9, 12, 0, 0, 0, 12, 1); check("R3 wb rs2", 2'b00, 2'b10, 1'b0);
        drive(9, 12, 12, 1, 0, 9, 1); check("R3 wb with mem on other", 2'b10, 2'b01, 1'b0);
    endtask

    task automatic t_both();
        drive(6, 6, 6, 1, 0, 6, 1);  check("R4 R9 mem over wb", 2'b01, 2'b01, 1'b0);
        drive(6, 6, 0, 0, 0, 6, 1);  check("R9 both wb", 2'b10, 2'b10, 1'b0);
    endtask

    task automatic t_nowrite();
        drive(4, 5, 4, 0, 0, 5, 1);  check("R5 mem disabled", 2'b00, 2'b10, 1'b0);
        drive(4, 5, 4, 0, 1, 5, 0);  check("R5 disabled load and wb", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_zero();
        drive(0, 0, 0, 1, 1, 0, 1);  check("R6 x0 never bypassed", 2'b00, 2'b00, 1'b0);
        drive(0, 0, 0, 1, 0, 0, 1);  check("R6 x0 non-load", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_load();
        drive(8, 2, 8, 1, 1, 0, 0);  check("R7 load rs1 regfile", 2'b00, 2'b00, 1'b1);
        drive(8, 2, 8, 1, 1, 8, 1);  check("R7 load rs1 falls to wb", 2'b10, 2'b00, 1'b1);
        drive(1, 14, 14, 1, 1, 1, 1); check("R7 load rs2", 2'b10, 2'b00, 1'b1);
    endtask

    task automatic t_noload();
        drive(11, 12, 10, 1, 1, 11, 1); check("R8 load other reg", 2'b10, 2'b00, 1'b0);
        drive(10, 10, 10, 1, 0, 0, 0);  check("R8 non-load match", 2'b01, 2'b01, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 10000; i++) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_idle();
        t_mem();
        t_wb();
        t_both();
        t_nowrite();
        t_zero();
        t_load();
        t_noload();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule